// File: doc/BRIEF.md
# Bus-Start Watchdog Timer

This block supervises a processor that shares a two-wire serial bus with it. The processor proves that it is alive by putting a START condition on the bus: the data line falls while the clock line is high. Each START clears an internal counter. The counter advances on a prescaled timebase tick. If the counter reaches the selected interval before the next START arrives, the block emits a one-cycle timeout pulse, which the surrounding logic turns into a system reset.

A two-bit select register picks the interval. One code switches the watchdog off, and the other three choose a long, a medium or a short period. The register stands in for nonvolatile storage. It takes a power-up value and keeps it through the system reset, so it changes only when it is written. A write can be blocked by raising a protect pin while a protect-enable bit is set.

Top module: `bus_kick_watchdog`

## Requirements
- R1: Each bus line passes through a two-flop synchroniser. `kick` pulses for one cycle when two consecutive synchronised samples show the data line going from 1 to 0 while the clock line is 1 in both samples. A data fall while the clock line is 0 produces no pulse.
- R2: One START condition gives exactly one `kick` cycle. `kick` is never high on two consecutive cycles.
- R3: The select codes are 2'b00 = off (never times out), 2'b01 = LIMIT_LONG ticks, 2'b10 = LIMIT_MID ticks and 2'b11 = LIMIT_SHORT ticks. With no START, `timeout` rises in the cycle after the clock edge that samples the Nth `tick` since the last restart, where N is the selected limit.
- R4: A START clears the count. When `kick` and the expiring `tick` fall on the same cycle, the restart wins and no timeout is produced.
- R5: A write (`wr_en` = 1) loads `wr_sel` into `sel_q` on the next edge, unless `wp_pin` = 1 and `prot_en` = 1, in which case `sel_q` keeps its value.
- R6: `timeout` lasts exactly one cycle. The count then restarts from zero, so a further timeout follows after another N ticks.
- R7: `sel_q` starts at INIT_SEL (default 2'b00) and is not altered by `rst_n`.
- R8: While `rst_n` = 0, the count is held at zero, `timeout` and `kick` stay 0, and ticks are not counted.
- R9: If the period is shortened to a limit at or below the current count, `timeout` fires on the next `tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle timebase strobe (nominally 1 ms) |
| sda_in | input | 1 | Sampled bus data line, asynchronous |
| scl_in | input | 1 | Sampled bus clock line, asynchronous |
| wp_pin | input | 1 | Write-protect pin |
| prot_en | input | 1 | Protect-enable bit |
| wr_en | input | 1 | Select-register write strobe |
| wr_sel | input | 2 | Value to write into the select register |
| sel_q | output | 2 | Current period select code |
| kick | output | 1 | One-cycle START-detected pulse |
| timeout | output | 1 | One-cycle watchdog expiry pulse |

## Verification
A START can be recognised in the same cycle that the final tick of a period arrives, so a restart and an expiry compete. The bench provokes this by counting to one tick short of the medium limit. It then lowers the data line so that the `kick` cycle, two edges later, coincides with a driven `tick`. The result is judged on three points: `timeout` must stay low, `kick` must be observed in that cycle, and a full fresh period must then pass before the next timeout.

// File: rtl/wdt_pkg.sv
// Package: shared period-select encoding for the bus-start watchdog.
// Assumes a two-bit select field; code values are fixed by behaviour.
package wdt_pkg;
    typedef enum logic [1:0] {
        PER_OFF   = 2'b00,
        PER_LONG  = 2'b01,
        PER_MID   = 2'b10,
        PER_SHORT = 2'b11
    } period_e;
endpackage

// File: rtl/wdt_line_sync.sv
// Module: multi-flop synchroniser for one asynchronous bus line.
// Assumes STAGES >= 2. It resets to 1, the idle level of an open-drain bus,
// so that leaving reset cannot look like an edge.
module wdt_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // shift the raw line through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/wdt_start_detect.sv
// Module: decodes a bus START (data 1->0 while clock stays 1) from
// synchronised samples. Assumes the sampling clock is much faster than the bus.
module wdt_start_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sda_in,
    input  logic scl_in,
    output logic kick
);
    logic sda_s, scl_s, sda_p, scl_p;

    wdt_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
        .clk(clk), .rst_n(rst_n), .din(sda_in), .dout(sda_s));
    wdt_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
        .clk(clk), .rst_n(rst_n), .din(scl_in), .dout(scl_s));

    // keep the previous synchronised sample of each line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_p <= 1'b1;
            scl_p <= 1'b1;
        end else begin
            sda_p <= sda_s;
            scl_p <= scl_s;
        end
    end

    // START: data falls between two samples, clock high in both
    assign kick = rst_n && sda_p && !sda_s && scl_p && scl_s;

    // R2: a START yields a single-cycle kick
    a_r2_kick_single: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !kick);
endmodule

// File: rtl/wdt_period_reg.sv
// Module: the period-select register, modelling nonvolatile bits. It has a
// power-up value, ignores the system reset and honours the write lock.
module wdt_period_reg #(
    parameter logic [1:0] INIT_SEL = 2'b00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wp_pin,
    input  logic       prot_en,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    output logic [1:0] sel_q
);
    logic [1:0] sel_r = INIT_SEL;
    logic       locked;

    assign locked = wp_pin && prot_en;

    // load a new code only through an unlocked write
    always_ff @(posedge clk) begin
        if (wr_en && !locked) sel_r <= wr_sel;
    end

    assign sel_q = sel_r;

    // R5: a locked write leaves the code unchanged
    a_r5_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && locked) |=> $stable(sel_q));
    // R7: the system reset alone never changes the code
    a_r7_reset_keeps: assert property (@(posedge clk)
        (!rst_n && !wr_en) |=> $stable(sel_q));
endmodule

// File: rtl/wdt_counter.sv
// Module: tick counter with a selectable limit. It restarts on a kick or on
// expiry and emits a one-cycle timeout. Assumes every limit is >= 2.
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int LIMIT_LONG  = 1400,
    parameter int LIMIT_MID   = 200,
    parameter int LIMIT_SHORT = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       kick,
    input  logic [1:0] sel,
    output logic       timeout
);
    localparam int MAX_LIM = (LIMIT_LONG > LIMIT_MID)
        ? ((LIMIT_LONG > LIMIT_SHORT) ? LIMIT_LONG : LIMIT_SHORT)
        : ((LIMIT_MID > LIMIT_SHORT) ? LIMIT_MID : LIMIT_SHORT);
    localparam int CNT_W = $clog2(MAX_LIM + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;
    logic             enabled;
    logic             expire;

    // pick the final count value for the selected period
    always_comb begin
        enabled = 1'b1;
        unique case (period_e'(sel))
            PER_LONG:  last = CNT_W'(LIMIT_LONG - 1);
            PER_MID:   last = CNT_W'(LIMIT_MID - 1);
            PER_SHORT: last = CNT_W'(LIMIT_SHORT - 1);
            default: begin
                last    = '0;
                enabled = 1'b0;
            end
        endcase
    end

    // at-or-above compare so that shortening the period cannot skip expiry
    assign expire = enabled && tick && !kick && (cnt >= last);

    // advance on ticks; clear on reset, kick, disable or expiry
    always_ff @(posedge clk) begin
        if (!rst_n || kick || !enabled || expire) cnt <= '0;
        else if (tick)                            cnt <= cnt + 1'b1;
    end

    // register the expiry as a single-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) timeout <= 1'b0;
        else        timeout <= expire;
    end

    // R6: the timeout never lasts two cycles
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);
    // R3: the off code never times out
    a_r3_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (period_e'(sel) == PER_OFF) |=> !timeout);
    // R4: a kick clears the count and suppresses expiry
    a_r4_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt == '0) && !timeout);
    // R8: reset holds the counter cleared
    a_r8_reset_hold: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0) && !timeout);
endmodule

// File: rtl/bus_kick_watchdog.sv
// Module: top of the bus-start watchdog. It ties together START decoding,
// the lockable period register and the expiry counter. Assumes tick is a
// single-cycle strobe from a shared prescaler.
module bus_kick_watchdog #(
    parameter int         SYNC_STAGES = 2,
    parameter int         LIMIT_LONG  = 1400,
    parameter int         LIMIT_MID   = 200,
    parameter int         LIMIT_SHORT = 25,
    parameter logic [1:0] INIT_SEL    = 2'b00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       sda_in,
    input  logic       scl_in,
    input  logic       wp_pin,
    input  logic       prot_en,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    output logic [1:0] sel_q,
    output logic       kick,
    output logic       timeout
);
    wdt_start_detect #(.SYNC_STAGES(SYNC_STAGES)) u_start (
        .clk(clk), .rst_n(rst_n), .sda_in(sda_in), .scl_in(scl_in),
        .kick(kick));

    wdt_period_reg #(.INIT_SEL(INIT_SEL)) u_sel (
        .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin), .prot_en(prot_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .sel_q(sel_q));

    wdt_counter #(
        .LIMIT_LONG(LIMIT_LONG), .LIMIT_MID(LIMIT_MID),
        .LIMIT_SHORT(LIMIT_SHORT)
    ) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick), .sel(sel_q),
        .timeout(timeout));

    // R1: no kick may arise while the reset is applied
    a_r1_no_kick_in_reset: assert property (@(posedge clk)
        !rst_n |-> !kick);
endmodule

// File: tb/sim_bus_kick_watchdog.sv
module sim_bus_kick_watchdog;
    localparam int CLK_PERIOD = 10;
    localparam int LL = 12, LM = 7, LS = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0, tick = 1'b0, sda = 1'b1, scl = 1'b1;
    logic wp = 1'b0, prot = 1'b0, wr_en = 1'b0;
    logic [1:0] wr_sel = 2'b00;
    logic [1:0] sel_q;
    logic kick, timeout;
    int n_chk = 0, n_fail = 0, kick_seen = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_kick_watchdog #(.LIMIT_LONG(LL), .LIMIT_MID(LM), .LIMIT_SHORT(LS)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sda_in(sda), .scl_in(scl),
        .wp_pin(wp), .prot_en(prot), .wr_en(wr_en), .wr_sel(wr_sel),
        .sel_q(sel_q), .kick(kick), .timeout(timeout));

    always @(negedge clk) if (kick) kick_seen++;

    function automatic int lim(input logic [1:0] s);
        return (s == 2'b01) ? LL : (s == 2'b10) ? LM : (s == 2'b11) ? LS : 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic do_tick();
        tick = 1'b1; step(); tick = 1'b0;
    endtask

    task automatic wr(input logic [1:0] v);
        wr_sel = v; wr_en = 1'b1; step(); wr_en = 1'b0;
    endtask

    task automatic send_start();
        int k0;
        k0 = kick_seen;
        sda = 1'b0; step(); step();
        check("R1 kick visible two edges after START", int'(kick), 1);
        step();
        sda = 1'b1; repeat (3) step();
        check("R2 one kick per START", kick_seen - k0, 1);
    endtask

    task automatic sweep_period(input logic [1:0] s);
        int l;
        l = lim(s);
        wr(s);
        send_start();
        for (int r = 0; r < 2; r++) begin
            for (int k = 1; k < l; k++) begin
                do_tick();
                check("R3 no timeout before limit", int'(timeout), 0);
            end
            do_tick();
            check("R3 timeout at limit", int'(timeout), 1);
            step();
            check("R6 timeout lasts one cycle", int'(timeout), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int k0;
        #1;
        check("R7 power-up select value", int'(sel_q), 0);
        step(); step();
        check("R8 timeout low in reset", int'(timeout), 0);
        check("R8 kick low in reset", int'(kick), 0);
        rst_n = 1'b1; repeat (3) step();
        check("R1 no kick after reset release", kick_seen, 0);

        // R3 sweep of every enabled period, two expiries each (R6)
        sweep_period(2'b01);
        sweep_period(2'b10);
        sweep_period(2'b11);

        // R3 off code: no timeout however many ticks pass
        wr(2'b00);
        for (int k = 0; k < 3 * LL; k++) begin
            do_tick();
            check("R3 off never times out", int'(timeout), 0);
        end

        // R1 data fall with the clock line low is not a START
        k0 = kick_seen;
        scl = 1'b0; step(); sda = 1'b0; repeat (4) step();
        sda = 1'b1; step(); scl = 1'b1; repeat (4) step();
        check("R1 fall with clock low ignored", kick_seen - k0, 0);

        // R5 write-lock sweep over pin, enable and every code
        for (int w = 0; w < 2; w++)
            for (int p = 0; p < 2; p++)
                for (int v = 0; v < 4; v++) begin
                    wp = 1'b0; prot = 1'b0; wr(2'(v) ^ 2'b11);
                    wp = 1'(w); prot = 1'(p); wr(2'(v));
                    check("R5 select write/lock",
                          int'(sel_q), (w == 1 && p == 1) ? (v ^ 3) : v);
                end
        wp = 1'b0; prot = 1'b0;

        // R4 kick meets the final tick of a medium period
        wr(2'b10); send_start();
        for (int k = 1; k < LM; k++) do_tick();
        check("R4 no timeout before collision", int'(timeout), 0);
        sda = 1'b0; step(); step();
        check("R4 kick in collision cycle", int'(kick), 1);
        tick = 1'b1; step(); tick = 1'b0;
        check("R4 restart beats expiry", int'(timeout), 0);
        sda = 1'b1; repeat (3) step();
        for (int k = 1; k < LM; k++) begin
            do_tick();
            check("R4 full period after restart", int'(timeout), 0);
        end
        do_tick();
        check("R4 expiry after fresh period", int'(timeout), 1);

        // R9 shrink the period below the current count
        wr(2'b01); send_start();
        for (int k = 0; k < 5; k++) do_tick();
        check("R9 long period still running", int'(timeout), 0);
        wr(2'b11);
        do_tick();
        check("R9 shrink fires on next tick", int'(timeout), 1);

        // R8 reset holds the count; R7 reset keeps the select code
        step(); rst_n = 1'b0;
        for (int k = 0; k < 2 * LS; k++) begin
            do_tick();
            check("R8 no timeout while reset", int'(timeout), 0);
        end
        rst_n = 1'b1; step();
        check("R7 select survives reset", int'(sel_q), 3);
        for (int k = 1; k < LS; k++) begin
            do_tick();
            check("R8 count cleared by reset", int'(timeout), 0);
        end
        do_tick();
        check("R8 full period after reset", int'(timeout), 1);

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule